// File: doc/BRIEF.md
# 16-bit Capture/Compare Timer

This block is a 16-bit timer built around one free-running design clock. A count tick is derived from one of four source levels (the external timer clock, two auxiliary clocks, or the external clock inverted), each taken on its rising edge and then divided by 1, 2, 4 or 8. The counter can hold, count up to a limit, run freely through the full 16-bit range, or count up to a limit and back down. The limit is the register of channel 0. A rollover flag marks each return to zero.

Three channels share the counter. A channel in capture mode synchronises its input, detects the selected transition and stores the counter value in its register. A channel in compare mode raises an equal event when a counter step lands on its register value. That event, combined with channel 0's equal event, drives the channel output through one of eight output modes. All control and status pins are plain levels or single-cycle pulses. No pin carries a data stream, so no valid/ready handshake applies.

Top module: `ccu_timer16`

## Requirements
- R1: `src_sel` picks the tick source: 0 is a rising edge of `ext_clk`, 1 is a rising edge of `aux_clk_a`, 2 is a rising edge of `aux_clk_b`, 3 is a falling edge of `ext_clk`. An edge is seen when the selected level is high in a cycle and was low in the previous cycle. With `div_sel` = n, one count step happens on every 2^n-th source edge, counted from a clear.
- R2: With `cnt_mode` = 0 the counter does not move.
- R3: With `cnt_mode` = 1, a step from a value at or above the channel 0 register goes to 0 and sets `roll_flag`; any other step adds 1.
- R4: With `cnt_mode` = 2 the counter adds 1 on each step and wraps from FFFFh to 0. That wrap sets `roll_flag`.
- R5: With `cnt_mode` = 3 the counter rises to the channel 0 register value and then falls. A step that lands on 0 while falling sets `roll_flag`, and counting turns upward again. `roll_flag` is sticky until a `roll_flag_clr` pulse, and a set in the same cycle wins.
- R6: After reset, every register and flag is 0. `cnt_clr` zeroes the counter and the prescaler and makes the count direction upward in the next cycle. It overrides any step in that cycle.
- R7: In capture mode (`ch_cap_mode` bit = 1), the edge field is 2'b01 for rising, 2'b10 for falling, 2'b11 for both and 2'b00 for none. The input passes two synchroniser flops and an edge-detect flop. A transition set up before clock edge k is stored at edge k+2, holding the counter value that was present just before edge k+2.
- R8: A capture sets the channel flag. A capture while the flag is already set also sets the channel overflow flag. Both flags are sticky until their clear pulse, and a set wins over a clear in the same cycle.
- R9: In compare mode, a counter step (not a clear) that makes the counter equal to the channel register is an equal event. The channel flag is set at the following clock edge.
- R10: Output modes (3-bit field per channel): 0 copies `ch_sw_out`, 1 sets on the equal event, 4 toggles on it, 5 clears on it. The output updates at the clock edge after the event.
- R11: Mode 2 toggles on the equal event and clears on channel 0's equal event. Mode 3 sets and clears the same way. Mode 6 toggles on the equal event and sets on channel 0's equal event. Mode 7 clears and sets the same way. When both events coincide, the channel 0 action wins.
- R12: `ch_wr_en` loads `ch_wr_data` into the channel register at the next edge. A capture in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_clk | input | 1 | External timer clock level |
| aux_clk_a | input | 1 | First auxiliary clock level |
| aux_clk_b | input | 1 | Second auxiliary clock level |
| src_sel | input | 2 | Tick source select |
| div_sel | input | DIV_W | Prescale exponent |
| cnt_mode | input | 2 | 0 hold, 1 up, 2 free, 3 up/down |
| cnt_clr | input | 1 | Clear counter and prescaler |
| cnt_o | output | CNT_W | Counter value |
| roll_flag | output | 1 | Rollover flag |
| roll_flag_clr | input | 1 | Clear pulse for rollover flag |
| ch_cap_mode | input | NCH | Per channel: 1 capture, 0 compare |
| ch_edge | input | 2*NCH | Per channel capture edge field |
| ch_omode | input | 3*NCH | Per channel output mode |
| ch_sw_out | input | NCH | Per channel direct output level |
| ch_cap_in | input | NCH | Capture inputs |
| ch_wr_en | input | NCH | Per channel register write |
| ch_wr_data | input | CNT_W | Write data shared by channels |
| ch_reg | output | CNT_W*NCH | Channel register values |
| ch_flag | output | NCH | Channel event flags |
| ch_flag_clr | input | NCH | Clear pulses for channel flags |
| ch_ovf | output | NCH | Capture overflow flags |
| ch_ovf_clr | input | NCH | Clear pulses for overflow flags |
| ch_out | output | NCH | Channel outputs |

## Verification
A wrong prescaler count or a lost source edge shows on `cnt_o` as a step taken or missed at the next due tick, within 2^n source edges. A wrong direction bit in up/down mode shows on the very next step and then at every step after it. A synchroniser stage that is missing or extra moves the captured value and the flag by one cycle, which shows in `ch_reg` and `ch_flag` one edge after the capture. A wrong output-mode decision shows on `ch_out` one edge after an equal event. The bench predicts every output in every cycle, so each of these faults is reported in the first cycle it becomes visible.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  typedef enum logic [1:0] {
    CNT_HALT = 2'd0,
    CNT_UP   = 2'd1,
    CNT_FREE = 2'd2,
    CNT_UPDN = 2'd3
  } cnt_mode_e;

  localparam logic [2:0] OM_DIRECT  = 3'd0;
  localparam logic [2:0] OM_SET     = 3'd1;
  localparam logic [2:0] OM_TOG_CLR = 3'd2;
  localparam logic [2:0] OM_SET_CLR = 3'd3;
  localparam logic [2:0] OM_TOG     = 3'd4;
  localparam logic [2:0] OM_CLR     = 3'd5;
  localparam logic [2:0] OM_TOG_SET = 3'd6;
  localparam logic [2:0] OM_CLR_SET = 3'd7;

  // Next output level; a channel-0 action is applied last so it wins.
  function automatic logic next_out(input logic [2:0] m, input logic cur,
                                    input logic eq, input logic eq0, input logic sw);
    logic r;
    r = cur;
    unique case (m)
      OM_DIRECT:  r = sw;
      OM_SET:     if (eq) r = 1'b1;
      OM_TOG_CLR: begin if (eq) r = ~cur; if (eq0) r = 1'b0; end
      OM_SET_CLR: begin if (eq) r = 1'b1; if (eq0) r = 1'b0; end
      OM_TOG:     if (eq) r = ~cur;
      OM_CLR:     if (eq) r = 1'b0;
      OM_TOG_SET: begin if (eq) r = ~cur; if (eq0) r = 1'b1; end
      OM_CLR_SET: begin if (eq) r = 1'b0; if (eq0) r = 1'b1; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ccu_tick_gen.sv
module ccu_tick_gen #(
  parameter int SEL_W = 2,
  parameter int DIV_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [(1<<SEL_W)-1:0] src_lvl,
  input  logic [SEL_W-1:0]      src_sel,
  input  logic [DIV_W-1:0]      div_sel,
  input  logic                  clr,
  output logic                  tick
);
  localparam int PRE_W = (1 << DIV_W) - 1;

  logic             lvl, prev, raw;
  logic [PRE_W-1:0] pre, pre_lim;

  assign lvl     = src_lvl[src_sel];
  assign raw     = lvl & ~prev;
  assign pre_lim = PRE_W'((32'd1 << div_sel) - 32'd1);
  assign tick    = raw & (pre >= pre_lim) & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= 1'b0;
      pre  <= '0;
    end else begin
      prev <= lvl;
      if (clr)
        pre <= '0;
      else if (raw)
        pre <= (pre >= pre_lim) ? '0 : pre + 1'b1;
    end
  end

  // R1: a divided tick never repeats on the next cycle when dividing
  assert_no_back_to_back_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_sel != '0) |=> (!tick || div_sel == '0));
endmodule

// File: rtl/ccu_counter.sv
module ccu_counter
  import ccu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] top,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             upd,
  output logic             tifg
);
  cnt_mode_e        md;
  logic [CNT_W-1:0] nxt;
  logic             dn, nxt_dn, hit0;

  assign md = cnt_mode_e'(mode);

  always_comb begin
    nxt    = cnt;
    nxt_dn = dn;
    hit0   = 1'b0;
    unique case (md)
      CNT_HALT: ;
      CNT_UP: begin
        if (cnt >= top) begin nxt = '0; hit0 = 1'b1; end
        else nxt = cnt + 1'b1;
      end
      CNT_FREE: begin
        nxt  = cnt + 1'b1;
        hit0 = (cnt == '1);
      end
      CNT_UPDN: begin
        if (!dn) begin
          if (cnt >= top) begin
            nxt_dn = 1'b1;
            nxt    = (cnt == '0) ? '0 : cnt - 1'b1;
          end else nxt = cnt + 1'b1;
        end else if (cnt <= CNT_W'(1)) begin
          nxt = '0; nxt_dn = 1'b0; hit0 = 1'b1;
        end else nxt = cnt - 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; dn <= 1'b0; upd <= 1'b0; tifg <= 1'b0;
    end else begin
      if (clr) begin
        cnt <= '0; dn <= 1'b0; upd <= 1'b0;
      end else if (tick && md != CNT_HALT) begin
        cnt <= nxt; dn <= nxt_dn; upd <= 1'b1;
      end else upd <= 1'b0;
      if (tick && md != CNT_HALT && hit0) tifg <= 1'b1;
      else if (flag_clr) tifg <= 1'b0;
    end
  end

  assert_halt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (md == CNT_HALT && !clr) |=> $stable(cnt));
  assert_up_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && md == CNT_UP && cnt >= top) |=> (cnt == '0 && tifg));
  assert_free_increment_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && md == CNT_FREE) |=> cnt == CNT_W'($past(cnt) + 1'b1));
  assert_updn_bottom_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && md == CNT_UPDN && dn && cnt == CNT_W'(1)) |=> (cnt == '0 && tifg));
  assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !upd));
endmodule

// File: rtl/ccu_channel.sv
module ccu_channel
  import ccu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             upd,
  input  logic             cap_mode,
  input  logic [1:0]       edge_sel,
  input  logic [2:0]       omode,
  input  logic             sw_out,
  input  logic             cap_in,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             flag_clr,
  input  logic             ovf_clr,
  input  logic             eq0,
  output logic [CNT_W-1:0] ccr,
  output logic             eq,
  output logic             flag,
  output logic             ovf,
  output logic             out
);
  logic [2:0] sy;
  logic       rise, fall, cap_ev;

  assign rise   = sy[1] & ~sy[2];
  assign fall   = ~sy[1] & sy[2];
  assign cap_ev = cap_mode & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
  assign eq     = ~cap_mode & upd & (cnt == ccr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy <= '0; ccr <= '0; flag <= 1'b0; ovf <= 1'b0; out <= 1'b0;
    end else begin
      sy <= {sy[1:0], cap_in};
      if (cap_ev)     ccr <= cnt;
      else if (wr_en) ccr <= wr_data;
      if (cap_ev | eq)   flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (cap_ev & flag) ovf <= 1'b1;
      else if (ovf_clr)  ovf <= 1'b0;
      out <= next_out(omode, out, eq, eq0, sw_out);
    end
  end

  assert_capture_stores_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> ccr == $past(cnt));
  assert_capture_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && flag) |=> ovf);
  assert_equal_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eq |=> flag);
  assert_set_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (omode == OM_SET && eq) |=> out);
  assert_ch0_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (omode == OM_SET_CLR && eq0) |=> !out);
endmodule

// File: rtl/ccu_timer16.sv
module ccu_timer16 #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3,
  parameter int DIV_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_clk,
  input  logic               aux_clk_a,
  input  logic               aux_clk_b,
  input  logic [1:0]         src_sel,
  input  logic [DIV_W-1:0]   div_sel,
  input  logic [1:0]         cnt_mode,
  input  logic               cnt_clr,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               roll_flag,
  input  logic               roll_flag_clr,
  input  logic [NCH-1:0]     ch_cap_mode,
  input  logic [2*NCH-1:0]   ch_edge,
  input  logic [3*NCH-1:0]   ch_omode,
  input  logic [NCH-1:0]     ch_sw_out,
  input  logic [NCH-1:0]     ch_cap_in,
  input  logic [NCH-1:0]     ch_wr_en,
  input  logic [CNT_W-1:0]   ch_wr_data,
  output logic [CNT_W*NCH-1:0] ch_reg,
  output logic [NCH-1:0]     ch_flag,
  input  logic [NCH-1:0]     ch_flag_clr,
  output logic [NCH-1:0]     ch_ovf,
  input  logic [NCH-1:0]     ch_ovf_clr,
  output logic [NCH-1:0]     ch_out
);
  logic           tick, upd;
  logic [3:0]     src_lvl;
  logic [NCH-1:0] eq_v;

  assign src_lvl = {~ext_clk, aux_clk_b, aux_clk_a, ext_clk};

  ccu_tick_gen #(.SEL_W(2), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .src_sel(src_sel),
    .div_sel(div_sel), .clr(cnt_clr), .tick(tick)
  );

  ccu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(cnt_clr), .mode(cnt_mode),
    .top(ch_reg[CNT_W-1:0]), .flag_clr(roll_flag_clr), .cnt(cnt_o),
    .upd(upd), .tifg(roll_flag)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    ccu_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_o), .upd(upd),
      .cap_mode(ch_cap_mode[c]), .edge_sel(ch_edge[2*c +: 2]),
      .omode(ch_omode[3*c +: 3]), .sw_out(ch_sw_out[c]),
      .cap_in(ch_cap_in[c]), .wr_en(ch_wr_en[c]), .wr_data(ch_wr_data),
      .flag_clr(ch_flag_clr[c]), .ovf_clr(ch_ovf_clr[c]), .eq0(eq_v[0]),
      .ccr(ch_reg[CNT_W*c +: CNT_W]), .eq(eq_v[c]), .flag(ch_flag[c]),
      .ovf(ch_ovf[c]), .out(ch_out[c])
    );
  end
endmodule

// File: tb/sim_ccu_timer16.sv
module sim_ccu_timer16;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ext_clk, aux_clk_a, aux_clk_b;
  logic [1:0]  src_sel = 2'd0, div_sel = 2'd0, cnt_mode = 2'd0;
  logic        cnt_clr = 1'b0, roll_flag_clr = 1'b0, roll_flag;
  logic [15:0] cnt_o, ch_wr_data = 16'd0;
  logic [2:0]  ch_cap_mode = '0, ch_sw_out = '0, ch_cap_in = '0, ch_wr_en = '0;
  logic [2:0]  ch_flag, ch_flag_clr = '0, ch_ovf, ch_ovf_clr = '0, ch_out;
  logic [5:0]  ch_edge = '0;
  logic [8:0]  ch_omode = '0;
  logic [47:0] ch_reg;

  int    n_chk = 0, n_bad = 0;
  string cur_req = "R6";
  int    k = 0;

  always #2 clk = ~clk;

  always @(negedge clk) k <= k + 1;
  assign ext_clk   = k[0];
  assign aux_clk_a = k[1];
  assign aux_clk_b = (k % 3) == 0;

  ccu_timer16 u0 (.*);

  // reference model state
  logic [15:0] m_cnt, m_ccr [3];
  logic        m_prev, m_dn, m_upd, m_tifg;
  int          m_pre;
  logic [2:0]  m_s1, m_s2, m_s3, m_flag, m_ovf, m_out;

  function automatic logic ref_out(input logic [2:0] m, input logic cur,
                                   input logic e, input logic e0, input logic sw);
    logic v;
    v = cur;
    if (m == 3'd0) return sw;
    if (e) begin
      if (m == 3'd1 || m == 3'd3) v = 1'b1;
      else if (m == 3'd5 || m == 3'd7) v = 1'b0;
      else v = ~cur;
    end
    if (e0 && (m == 3'd2 || m == 3'd3)) v = 1'b0;
    if (e0 && (m == 3'd6 || m == 3'd7)) v = 1'b1;
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic lvl, raw, tk, wrapped, e0;
    logic [15:0] old_top;
    logic [2:0] eqv;
    int lim;
    if (!rst_n) begin
      m_cnt = 0; m_prev = 0; m_dn = 0; m_upd = 0; m_tifg = 0; m_pre = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_flag = 0; m_ovf = 0; m_out = 0;
      for (int c = 0; c < 3; c++) m_ccr[c] = 0;
    end else begin
      case (src_sel)
        2'd0: lvl = ext_clk;
        2'd1: lvl = aux_clk_a;
        2'd2: lvl = aux_clk_b;
        default: lvl = !ext_clk;
      endcase
      raw = lvl && !m_prev;
      m_prev = lvl;
      lim = (1 << div_sel) - 1;
      tk = raw && (m_pre >= lim) && !cnt_clr;
      old_top = m_ccr[0];
      for (int c = 0; c < 3; c++)
        eqv[c] = !ch_cap_mode[c] && m_upd && (m_cnt == m_ccr[c]);
      e0 = eqv[0];
      for (int c = 0; c < 3; c++) begin
        logic ri, fa, cap;
        ri  = m_s2[c] && !m_s3[c];
        fa  = !m_s2[c] && m_s3[c];
        cap = ch_cap_mode[c] && ((ch_edge[2*c] && ri) || (ch_edge[2*c+1] && fa));
        if (cap) m_ccr[c] = m_cnt;
        else if (ch_wr_en[c]) m_ccr[c] = ch_wr_data;
        if (cap && m_flag[c]) m_ovf[c] = 1;
        else if (ch_ovf_clr[c]) m_ovf[c] = 0;
        if (cap || eqv[c]) m_flag[c] = 1;
        else if (ch_flag_clr[c]) m_flag[c] = 0;
        m_out[c] = ref_out(ch_omode[3*c +: 3], m_out[c], eqv[c], e0, ch_sw_out[c]);
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ch_cap_in;
      wrapped = 0;
      if (cnt_clr) begin
        m_cnt = 0; m_dn = 0; m_upd = 0; m_pre = 0;
      end else begin
        if (raw) m_pre = (m_pre >= lim) ? 0 : m_pre + 1;
        m_upd = 0;
        if (tk && cnt_mode != 2'd0) begin
          m_upd = 1;
          if (cnt_mode == 2'd1) begin
            if (m_cnt >= old_top) begin m_cnt = 0; wrapped = 1; end
            else m_cnt = m_cnt + 1;
          end else if (cnt_mode == 2'd2) begin
            wrapped = (m_cnt == 16'hFFFF);
            m_cnt = m_cnt + 1;
          end else if (!m_dn) begin
            if (m_cnt >= old_top) begin
              m_dn = 1;
              if (m_cnt != 0) m_cnt = m_cnt - 1;
            end else m_cnt = m_cnt + 1;
          end else begin
            if (m_cnt <= 1) begin m_cnt = 0; m_dn = 0; wrapped = 1; end
            else m_cnt = m_cnt - 1;
          end
        end
      end
      if (wrapped) m_tifg = 1;
      else if (roll_flag_clr) m_tifg = 0;
    end
    #1;
    chk(cur_req, "counter", cnt_o, m_cnt);
    chk(cur_req, "roll_flag", roll_flag, m_tifg);
    for (int c = 0; c < 3; c++) begin
      chk(ch_cap_mode[c] ? "R7" : "R12", $sformatf("ch%0d reg", c), ch_reg[16*c +: 16], m_ccr[c]);
      chk(ch_cap_mode[c] ? "R8" : "R9", $sformatf("ch%0d flag", c), ch_flag[c], m_flag[c]);
      chk("R8", $sformatf("ch%0d ovf", c), ch_ovf[c], m_ovf[c]);
      chk(ch_omode[3*c +: 3] inside {3'd0, 3'd1, 3'd4, 3'd5} ? "R10" : "R11",
          $sformatf("ch%0d out", c), ch_out[c], m_out[c]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int c, input logic [15:0] d);
    @(negedge clk);
    ch_wr_data = d; ch_wr_en = 3'b001 << c;
    @(negedge clk);
    ch_wr_en = '0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    roll_flag_clr = 1; ch_flag_clr = '1; ch_ovf_clr = '1;
    @(negedge clk);
    roll_flag_clr = 0; ch_flag_clr = '0; ch_ovf_clr = '0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    summary();
    $finish;
  end

  initial begin
    cur_req = "R6";
    cyc(3);
    rst_n = 1;
    cyc(2);
    cur_req = "R12";
    wr(0, 16'd5); wr(1, 16'd2); wr(2, 16'd4);
    // R1: each source and prescale setting in turn
    cur_req = "R1";
    cnt_mode = 2'd2;
    for (int s = 0; s < 4; s++) begin
      src_sel = 2'(s); div_sel = 2'(s);
      cyc(20 + 10 * s);
    end
    src_sel = 2'd2; div_sel = 2'd0; cyc(15);
    // R2: hold mode with sources running
    cur_req = "R2";
    cnt_mode = 2'd0; cyc(20);
    // R6: clear pulse and held clear while counting
    cur_req = "R6";
    cnt_mode = 2'd2; src_sel = 2'd0; div_sel = 2'd1; cyc(7);
    cnt_clr = 1; cyc(1); cnt_clr = 0; cyc(5);
    cnt_clr = 1; cyc(3); cnt_clr = 0; cyc(6);
    // R3 with R10/R11 output modes
    cur_req = "R3";
    cnt_mode = 2'd1; div_sel = 2'd0;
    ch_omode = {3'd7, 3'd3, 3'd4};
    for (int i = 0; i < 6; i++) begin cyc(9); clear_flags(); end
    ch_omode = {3'd6, 3'd2, 3'd1}; cyc(40);
    ch_omode = {3'd5, 3'd1, 3'd0};
    for (int i = 0; i < 8; i++) begin ch_sw_out[0] = ~ch_sw_out[0]; cyc(3); end
    ch_omode = {3'd4, 3'd5, 3'd2}; cyc(30);
    // R5: up/down with two limits
    cur_req = "R5";
    cnt_mode = 2'd3; ch_omode = {3'd7, 3'd6, 3'd4};
    cyc(60);
    clear_flags();
    wr(0, 16'd1); cyc(20);
    wr(0, 16'd0); cyc(10);
    wr(0, 16'd6); cyc(50);
    // R7/R8: captures with edge selections, write collisions for R12
    cur_req = "R7";
    cnt_mode = 2'd2; ch_cap_mode = 3'b110; ch_edge = {2'b11, 2'b01, 2'b00};
    for (int i = 0; i < 70; i++) begin
      if (i % 5 == 0) ch_cap_in[1] = ~ch_cap_in[1];
      if (i % 7 == 0) ch_cap_in[2] = ~ch_cap_in[2];
      ch_wr_data = 16'(16'hA000 + i);
      ch_wr_en = (i % 3 == 0) ? 3'b010 : 3'b000;
      cyc(1);
    end
    ch_wr_en = '0;
    cur_req = "R8";
    clear_flags();
    ch_edge = {2'b00, 2'b10, 2'b00};
    for (int i = 0; i < 50; i++) begin
      if (i % 4 == 0) ch_cap_in = ~ch_cap_in;
      if (i % 9 == 0) begin ch_flag_clr = 3'b110; ch_ovf_clr = 3'b110; end
      else begin ch_flag_clr = 0; ch_ovf_clr = 0; end
      cyc(1);
    end
    ch_flag_clr = 0; ch_ovf_clr = 0;
    // R4: full-range free run through the wrap
    cur_req = "R4";
    ch_cap_mode = 3'b000; ch_omode = {3'd4, 3'd1, 3'd4};
    cnt_clr = 1; cyc(1); cnt_clr = 0;
    clear_flags();
    cnt_mode = 2'd2; src_sel = 2'd0; div_sel = 2'd0;
    cyc(131200);
    summary();
    $finish;
  end
endmodule